// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row-Only Refresh

This block sits between a simple request port and an asynchronous DRAM whose row and column addresses share one set of address pins. A requester presents a read or write with a flat address and, for a write, a data word. The controller splits the address into a row half and a column half. It then runs a fixed-length access cycle, counted in whole clock periods, that strobes the row, then the column, then precharges.

Refresh needs no help from the requester. A free-running interval timer raises a refresh demand once per interval. The controller then runs a cycle that pulses the row strobe with an internal row counter on the address pins and leaves the column strobe inactive. The row counter advances once per refresh. A demand that is waiting at a cycle boundary wins over a user request. The user request is then held off, not lost. Read data comes back with a one-clock valid pulse.

Top module: `dram_ras_ctrl`

## Requirements
- R1: While `rst_n` is low, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `rd_valid` is low. The refresh row counter and interval timer restart from zero, so the first refresh after reset drives row 0.
- R2: A request accepted at clock edge E (`req_valid` and `req_ready` both high) drives the row `req_addr[2*AW-1:AW]` on `dram_addr` for the clocks after E and E+1. `dram_ras_n` is low for exactly the three clocks following edges E+1, E+2 and E+3.
- R3: The column `req_addr[AW-1:0]` is on `dram_addr` for the clocks following E+2, E+3 and E+4. `dram_cas_n` is low only in the clock following E+3, and only while `dram_ras_n` is low.
- R4: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write word on `dram_dq_out` for the clocks following E+2, E+3 and E+4. For a read, `dram_we_n` stays high and `dram_dq_oe` stays low.
- R5: For a read, `rd_data` holds the value on `dram_dq_in` at edge E+4, the edge where CAS rises. `rd_valid` is high for exactly the one clock after E+4.
- R6: Consecutive falling edges of `dram_ras_n` are at least 6 clocks apart. Requests held back to back give exactly 6.
- R7: A refresh cycle holds `dram_ras_n` low for 3 clocks. During it, `dram_cas_n` and `dram_we_n` stay high and `dram_addr` does not change.
- R8: The refresh row counter is 12 bits wide and increments by one after each refresh, so successive refreshes drive consecutive rows.
- R9: With no user traffic, refresh row strobes fall exactly `REF_PERIOD` (512) clocks apart.
- R10: A pending refresh takes the next cycle boundary ahead of a waiting user request. The request stays pending and is served later, so a continuous stream of reads loses no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Row in the upper half, column in the lower half |
| req_wdata | input | DW | Write word |
| req_ready | output | 1 | Request taken at this clock edge if valid |
| rd_valid | output | 1 | One-clock read data strobe |
| rd_data | output | DW | Read word |
| dram_addr | output | AW | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DW | Data driven to the memory |
| dram_dq_oe | output | 1 | Output enable for dram_dq_out |
| dram_dq_in | input | DW | Data returned by the memory |

## Verification
Every result is counted from the edge E that accepts a request. The row strobe falls after E+1. The column moves onto the pins after E+2, CAS falls after E+3, and read data with its strobe appears after E+4. Tests drive inputs and sample outputs on falling clock edges, so each phase is read half a clock after the edge that sets it. Refresh timing is measured between refresh strobes that each start from an idle controller, which puts their spacing at exactly 512 clocks. The memory model returns a marker word whenever CAS is high, so a read captured at the wrong edge shows up in the data.

// File: rtl/dram_ras_ctrl.sv
module dram_ras_ctrl #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int REF_PERIOD = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   dram_addr,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic [DW-1:0]   dram_dq_out,
  output logic            dram_dq_oe,
  input  logic [DW-1:0]   dram_dq_in
);
  localparam int TW = $clog2(REF_PERIOD);
  localparam logic [TW-1:0] TMAX = TW'(REF_PERIOD - 1);
  localparam logic [2:0] PH_LAST = 3'd5;

  logic          busy, is_ref, is_wr, ref_pend;
  logic [2:0]    ph;
  logic [AW-1:0] row_q, col_q;
  logic [DW-1:0] wd_q;
  logic [11:0]   ref_row;
  logic [TW-1:0] tmr;

  logic boundary, start_ref, start_usr, rd_cap;
  assign boundary  = !busy || ph == PH_LAST;
  assign req_ready = boundary && !ref_pend;
  assign start_ref = boundary && ref_pend;
  assign start_usr = req_ready && req_valid;
  assign rd_cap    = busy && !is_ref && !is_wr && ph == 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= '0; is_ref <= 1'b0; is_wr <= 1'b0;
      row_q <= '0; col_q <= '0; wd_q <= '0;
      ref_row <= '0; tmr <= '0; ref_pend <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= rd_cap;
      if (rd_cap) rd_data <= dram_dq_in;

      tmr <= (tmr == TMAX) ? '0 : tmr + 1'b1;
      if (tmr == TMAX) ref_pend <= 1'b1;
      else if (start_ref) ref_pend <= 1'b0;

      if (busy && is_ref && ph == PH_LAST) ref_row <= ref_row + 1'b1;

      if (start_ref || start_usr) begin
        busy   <= 1'b1;
        ph     <= '0;
        is_ref <= start_ref;
        is_wr  <= start_usr && req_write;
        if (start_usr) begin
          row_q <= req_addr[2*AW-1:AW];
          col_q <= req_addr[AW-1:0];
          wd_q  <= req_wdata;
        end
      end else if (busy) begin
        if (ph == PH_LAST) begin
          busy <= 1'b0;
          ph   <= '0;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign dram_ras_n  = !(busy && ph >= 3'd1 && ph <= 3'd3);
  assign dram_cas_n  = !(busy && !is_ref && ph == 3'd3);
  assign dram_we_n   = !(busy && is_wr && ph >= 3'd2 && ph <= 3'd4);
  assign dram_dq_oe  = busy && is_wr && ph >= 3'd2 && ph <= 3'd4;
  assign dram_dq_out = wd_q;
  assign dram_addr   = is_ref ? ref_row[AW-1:0] : (ph <= 3'd1 ? row_q : col_q);
endmodule

// File: rtl/dram_ras_ctrl_chk.sv
module dram_ras_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic rd_valid
);
  AST_RESET_INACTIVE: assert property (@(posedge clk) !rst_n |=> (ras_n && cas_n && we_n && !rd_valid)); // R1
  AST_RAS_THREE_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |=> !ras_n ##1 !ras_n ##1 ras_n); // R2
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> !ras_n); // R3
  AST_CAS_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |=> cas_n); // R3
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n) (!cas_n && !we_n) |-> $past(!we_n)); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($rose(cas_n) && $past(!we_n)) |-> !we_n); // R4
  AST_DATA_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n) !cas_n |-> (dq_oe == !we_n)); // R4
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R5
  AST_RDV_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> ($past(!cas_n) && $past(we_n))); // R5
  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> ($past(ras_n, 1) && $past(ras_n, 2) && $past(ras_n, 3))); // R6
endmodule

bind dram_ras_ctrl dram_ras_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .rd_valid(rd_valid)
);

// File: tb/dram_ras_ctrl_tb.sv
module dram_ras_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
  logic [AW-1:0] dram_addr;

  always #2 clk = ~clk;

  assign dram_dq_in = dram_cas_n ? 16'hDEAD : (16'h5000 ^ {4'b0, dram_addr});

  dram_ras_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // refresh / spacing monitor
  int cyc = 0, last_fall = -1, ref_cnt = 0, six_cnt = 0;
  logic pr = 1'b1, saw_cas, addr_moved, we_seen;
  logic [AW-1:0] fall_addr;
  logic [AW-1:0] ref_addr [0:63];
  int ref_t [0:63];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pr && !dram_ras_n) begin
        if (last_fall >= 0) begin
          chk(cyc - last_fall >= 6, "R6 ras spacing", cyc - last_fall, 6);
          if (cyc - last_fall == 6) six_cnt++;
        end
        last_fall = cyc; saw_cas = 1'b0; addr_moved = 1'b0; we_seen = 1'b0;
        fall_addr = dram_addr;
      end
      if (!dram_ras_n) begin
        if (!dram_cas_n) saw_cas = 1'b1;
        if (dram_addr != fall_addr) addr_moved = 1'b1;
        if (!dram_we_n) we_seen = 1'b1;
      end
      if (!pr && dram_ras_n && !saw_cas) begin
        chk(!addr_moved && !we_seen, "R7 refresh addr/we", {addr_moved, we_seen}, 0);
        chk(cyc - last_fall == 3, "R7 refresh ras width", cyc - last_fall, 3);
        if (ref_cnt < 64) begin
          ref_addr[ref_cnt] = fall_addr;
          ref_t[ref_cnt] = last_fall;
        end
        ref_cnt++;
      end
    end
    pr = dram_ras_n;
  end

  // returns at the falling edge half a clock after accept edge E (phase 0)
  task automatic issue(input logic wr, input logic [2*AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      if (req_ready) begin
        @(posedge clk); @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!rd_valid, "R1 rd_valid low in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
    issue(1'b1, {r, c}, d);
    chk(dram_ras_n && dram_addr == r, "R2 row setup", dram_addr, r);
    @(negedge clk);
    chk(!dram_ras_n && dram_addr == r && dram_we_n, "R2 row hold", dram_addr, r);
    @(negedge clk);
    chk(dram_addr == c && dram_cas_n && !dram_ras_n, "R3 column setup", dram_addr, c);
    chk(!dram_we_n && dram_dq_oe && dram_dq_out == d, "R4 write setup", dram_dq_out, d);
    @(negedge clk);
    chk(!dram_cas_n && !dram_ras_n && dram_addr == c, "R3 cas low", dram_cas_n, 0);
    chk(!dram_we_n && dram_dq_out == d, "R4 write at cas", dram_dq_out, d);
    @(negedge clk);
    chk(dram_cas_n && dram_ras_n && dram_addr == c, "R3 cas rise/col hold", dram_addr, c);
    chk(!dram_we_n && dram_dq_oe && !rd_valid, "R4 write hold", dram_we_n, 0);
    @(negedge clk);
    chk(dram_we_n && !dram_dq_oe, "R4 write release", dram_we_n, 1);
  endtask

  task automatic t_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
    logic [DW-1:0] e = 16'h5000 ^ {4'b0, c};
    issue(1'b0, {r, c}, 16'hFFFF);
    chk(dram_addr == r, "R2 read row", dram_addr, r);
    @(negedge clk); @(negedge clk);
    chk(dram_we_n && !dram_dq_oe && dram_addr == c, "R4 read keeps we high", dram_we_n, 1);
    @(negedge clk);
    chk(!dram_cas_n && dram_we_n && !rd_valid, "R3 read cas", dram_cas_n, 0);
    @(negedge clk);
    chk(rd_valid, "R5 rd_valid at E+4", rd_valid, 1);
    chk(rd_data == e, "R5 read data", rd_data, e);
    @(negedge clk);
    chk(!rd_valid, "R5 rd_valid single pulse", rd_valid, 0);
  endtask

  task automatic t_refresh_idle;
    int k = ref_cnt;
    int n = 0;
    while (ref_cnt < k + 3 && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(ref_cnt >= k + 3, "R9 refreshes seen", ref_cnt - k, 3);
    chk(ref_t[k+2] - ref_t[k+1] == 512, "R9 refresh interval", ref_t[k+2] - ref_t[k+1], 512);
    chk(ref_addr[k+2] == ref_addr[k+1] + 1'b1, "R8 row increments",
        ref_addr[k+2], ref_addr[k+1] + 1);
    chk(ref_addr[0] == '0, "R1 first refresh row zero", ref_addr[0], 0);
  endtask

  task automatic t_stream;
    localparam int NR = 150;
    logic [DW-1:0] exp_q [0:NR-1];
    int got = 0, bad = 0;
    int k = ref_cnt;
    int s6 = six_cnt;
    fork
      begin
        req_valid = 1'b1; req_write = 1'b0;
        for (int i = 0; i < NR; i++) begin
          req_addr = {12'(i * 7), 12'(i * 13 + 5)};
          exp_q[i] = 16'h5000 ^ {4'b0, 12'(i * 13 + 5)};
          forever begin
            if (req_ready) begin
              @(posedge clk); @(negedge clk);
              break;
            end
            @(negedge clk);
          end
        end
        req_valid = 1'b0;
      end
      begin
        int n = 0;
        while (got < NR && n < 4000) begin
          @(negedge clk); n++;
          if (rd_valid) begin
            if (rd_data != exp_q[got]) bad++;
            got++;
          end
        end
      end
    join
    chk(got == NR, "R10 no read dropped", got, NR);
    chk(bad == 0, "R10 stream read data", bad, 0);
    chk(ref_cnt > k, "R10 refresh inserted in stream", ref_cnt - k, 1);
    chk(six_cnt > s6, "R6 back-to-back spacing of 6", six_cnt - s6, 1);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write(12'hABC, 12'h123, 16'h1F2E);
    t_read(12'h3C5, 12'h0F0);
    t_write(12'h000, 12'hFFF, 16'h8001);
    t_read(12'hFFF, 12'h000);
    t_refresh_idle();
    t_stream();
    t_read(12'h555, 12'hAAA);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule